// File: doc/BRIEF.md
# Bus Address Watchpoint Unit

This block snoops a shared memory bus and watches it for accesses that software wants to know about. It holds four independent watch units. Each unit is programmed with an inclusive address window, a mask of access kinds (read, write) and a mask of bus clients. When a snooped access falls inside the window, is of an enabled kind and comes from an enabled client, the unit records the access and flags it as pending.

Each unit is a two-state machine. In `U_IDLE` the unit has nothing recorded. The transition `IDLE->HELD` fires on the first hit and loads the address, operation, client id and size. In `U_HELD` these fields are frozen. Later hits take the `HELD->HELD merge` transition, which only ORs the new client into the recorded client set. A write to the unit's acknowledge register takes `HELD->IDLE` and clears the record. If a hit arrives in the same cycle as that write, the unit instead takes `HELD->HELD reload`, and the new access becomes the fresh first hit.

A separate interrupt stage keeps one pending bit per unit. A global enable mask gates these bits, and the block drives one interrupt line plus the index of the lowest-numbered enabled pending unit. Software clears pending bits through a global acknowledge register in which each bit written as 1 clears the matching pending bit. The register port uses 7-bit word addresses. Unit n occupies addresses n*16 to n*16+15, and the global registers start at 0x40. Register writes take effect at the next clock edge, and reads are combinational.

Top module: `bw_watch`

## Requirements
- R1: After reset, every configuration, record and pending register reads 0, `irq` is low and `irq_unit` is 0.
- R2: Per-unit register offsets: 0 first address, 1 last address, 2 operation mask (bit 0 enables reads, bit 1 enables writes), 3 client mask (bit k enables client id k). Values written to these registers read back unchanged.
- R3: A unit hits when `snp_valid` is 1, first ≤ `snp_addr` ≤ last (both ends included), the operation-mask bit for `snp_wr` is set, and bit `snp_cid` of the client mask is set. An access that fails any one of these conditions is ignored.
- R4: The first hit in IDLE records the address (offset 5), the operation (offset 6: 1 for write, 0 for read), the client id (offset 7) and the size (offset 8). These fields stay frozen under later hits until the unit is acknowledged.
- R5: The recorded client set (offset 4) holds the OR of one-hot(client id) over every hit since the record was loaded.
- R6: A write of any value to a unit's acknowledge register (offset 9) with no hit in that cycle clears the record to zero and returns the unit to IDLE. If a hit occurs in the same cycle, the unit instead reloads the record from that hit.
- R7: Every hit sets the unit's pending bit (global offset 3, bit n for unit n). Writing 1 to bit n of the global acknowledge register (offset 2) clears that bit. A hit in the same cycle as the acknowledge wins, and the bit stays set.
- R8: The global enable mask (offset 0) ANDed with the pending bits reads at global offset 1. `irq` is the OR of those masked bits.
- R9: `irq_unit` (also readable at global offset 4) gives the lowest-numbered unit whose masked pending bit is set.
- R10: The unit status register (offset 10) reads 1 while the unit is in HELD and 0 while it is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| snp_valid | input | 1 | Snooped access valid |
| snp_addr | input | 32 | Snooped access address |
| snp_cid | input | 4 | Snooped client id |
| snp_wr | input | 1 | Snooped access is a write |
| snp_size | input | 4 | Snooped access size |
| irq | output | 1 | OR of masked pending bits |
| irq_unit | output | 2 | Lowest masked pending unit |

## Verification
Two pairs of events can land in the same cycle: a hit and the global acknowledge of that unit's pending bit, and a hit and that unit's own acknowledge. The bench drives the register write and the snooped access on the same clock edge. For the first pair it then requires the pending bit to remain set and the frozen record to stay unchanged. For the second pair it requires the record to hold the colliding access as a new first hit, with the client set reduced to that access's client alone.

// File: rtl/bw_pkg.sv
`timescale 1ns/100ps
package bw_pkg;

    typedef enum logic [0:0] {
        U_IDLE = 1'b0,
        U_HELD = 1'b1
    } unit_state_e;

    localparam int OPM_W = 2;

    // per-unit register offsets
    localparam logic [3:0] OFS_FIRST  = 4'd0;
    localparam logic [3:0] OFS_LAST   = 4'd1;
    localparam logic [3:0] OFS_OPM    = 4'd2;
    localparam logic [3:0] OFS_CMASK  = 4'd3;
    localparam logic [3:0] OFS_CCLI   = 4'd4;
    localparam logic [3:0] OFS_CADDR  = 4'd5;
    localparam logic [3:0] OFS_COP    = 4'd6;
    localparam logic [3:0] OFS_CFIRST = 4'd7;
    localparam logic [3:0] OFS_CSIZE  = 4'd8;
    localparam logic [3:0] OFS_ACK    = 4'd9;
    localparam logic [3:0] OFS_STAT   = 4'd10;

    // global register offsets
    localparam logic [3:0] GOFS_MASK  = 4'd0;
    localparam logic [3:0] GOFS_MSTAT = 4'd1;
    localparam logic [3:0] GOFS_ACK   = 4'd2;
    localparam logic [3:0] GOFS_PEND  = 4'd3;
    localparam logic [3:0] GOFS_SEL   = 4'd4;

endpackage

// File: rtl/bw_match.sv
`timescale 1ns/100ps
module bw_match #(
    parameter int ADDR_W  = 32,
    parameter int NCLIENT = 16,
    parameter int CID_W   = 4
) (
    input  logic               valid_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [CID_W-1:0]   cid_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  first_i,
    input  logic [ADDR_W-1:0]  last_i,
    input  logic [1:0]         opm_i,
    input  logic [NCLIENT-1:0] cmask_i,
    output logic               hit_o,
    output logic [NCLIENT-1:0] cli_o
);

    logic [NCLIENT-1:0] onehot;
    logic               in_range;
    logic               op_ok;
    logic               cli_ok;

    always_comb begin
        onehot   = {{(NCLIENT-1){1'b0}}, 1'b1} << cid_i;
        in_range = (addr_i >= first_i) && (addr_i <= last_i);
        op_ok    = wr_i ? opm_i[1] : opm_i[0];
        cli_ok   = |(onehot & cmask_i);
        hit_o    = valid_i && in_range && op_ok && cli_ok;
        cli_o    = onehot & cmask_i & {NCLIENT{hit_o}};
    end

endmodule

// File: rtl/bw_unit.sv
`timescale 1ns/100ps
module bw_unit
    import bw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NCLIENT = 16,
    parameter int CID_W   = 4,
    parameter int SIZE_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [3:0]        ofs_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              snp_valid_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic [CID_W-1:0]  snp_cid_i,
    input  logic              snp_wr_i,
    input  logic [SIZE_W-1:0] snp_size_i,
    output logic              hit_o
);

    // configuration
    logic [ADDR_W-1:0]  first_q;
    logic [ADDR_W-1:0]  last_q;
    logic [OPM_W-1:0]   opm_q;
    logic [NCLIENT-1:0] cmask_q;

    // record
    logic [NCLIENT-1:0] cap_cli_q;
    logic [ADDR_W-1:0]  cap_addr_q;
    logic               cap_op_q;
    logic [CID_W-1:0]   cap_first_q;
    logic [SIZE_W-1:0]  cap_size_q;

    unit_state_e        st_q, st_d;
    logic               hit;
    logic [NCLIENT-1:0] hit_cli;
    logic               ack;
    logic               load_first;
    logic               merge;
    logic               clear;

    bw_match #(
        .ADDR_W  (ADDR_W),
        .NCLIENT (NCLIENT),
        .CID_W   (CID_W)
    ) u_match (
        .valid_i (snp_valid_i),
        .addr_i  (snp_addr_i),
        .cid_i   (snp_cid_i),
        .wr_i    (snp_wr_i),
        .first_i (first_q),
        .last_i  (last_q),
        .opm_i   (opm_q),
        .cmask_i (cmask_q),
        .hit_o   (hit),
        .cli_o   (hit_cli)
    );

    assign hit_o = hit;
    assign ack   = cfg_we_i && (ofs_i == OFS_ACK);

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
            opm_q   <= '0;
            cmask_q <= '0;
        end else if (cfg_we_i) begin
            case (ofs_i)
                OFS_FIRST: first_q <= wdata_i[ADDR_W-1:0];
                OFS_LAST:  last_q  <= wdata_i[ADDR_W-1:0];
                OFS_OPM:   opm_q   <= wdata_i[OPM_W-1:0];
                OFS_CMASK: cmask_q <= wdata_i[NCLIENT-1:0];
                default:   ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= U_IDLE;
        else        st_q <= st_d;
    end

    // next state and actions
    always_comb begin
        st_d       = st_q;
        load_first = 1'b0;
        merge      = 1'b0;
        clear      = 1'b0;
        unique case (st_q)
            U_IDLE: begin
                if (hit) begin
                    st_d       = U_HELD;
                    load_first = 1'b1;
                end
            end
            U_HELD: begin
                if (ack) begin
                    if (hit) begin
                        load_first = 1'b1;
                    end else begin
                        st_d  = U_IDLE;
                        clear = 1'b1;
                    end
                end else if (hit) begin
                    merge = 1'b1;
                end
            end
            default: st_d = U_IDLE;
        endcase
    end

    // record registers
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cap_cli_q   <= '0;
            cap_addr_q  <= '0;
            cap_op_q    <= 1'b0;
            cap_first_q <= '0;
            cap_size_q  <= '0;
        end else if (load_first) begin
            cap_cli_q   <= hit_cli;
            cap_addr_q  <= snp_addr_i;
            cap_op_q    <= snp_wr_i;
            cap_first_q <= snp_cid_i;
            cap_size_q  <= snp_size_i;
        end else if (merge) begin
            cap_cli_q   <= cap_cli_q | hit_cli;
        end
    end

    // readback
    always_comb begin
        rdata_o = '0;
        case (ofs_i)
            OFS_FIRST:  rdata_o = DATA_W'(first_q);
            OFS_LAST:   rdata_o = DATA_W'(last_q);
            OFS_OPM:    rdata_o = DATA_W'(opm_q);
            OFS_CMASK:  rdata_o = DATA_W'(cmask_q);
            OFS_CCLI:   rdata_o = DATA_W'(cap_cli_q);
            OFS_CADDR:  rdata_o = DATA_W'(cap_addr_q);
            OFS_COP:    rdata_o = DATA_W'(cap_op_q);
            OFS_CFIRST: rdata_o = DATA_W'(cap_first_q);
            OFS_CSIZE:  rdata_o = DATA_W'(cap_size_q);
            OFS_STAT:   rdata_o = DATA_W'(st_q == U_HELD);
            default:    rdata_o = '0;
        endcase
    end

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> snp_valid_i);                                                   // R3
    AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == U_IDLE && hit) |=> (st_q == U_HELD && cap_addr_q == $past(snp_addr_i))); // R4
    AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == U_HELD && !ack) |=> ($stable(cap_addr_q) && $stable(cap_first_q) && $stable(cap_size_q))); // R4
    AST_CLIENTS_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == U_HELD && !ack) |=> ((cap_cli_q & $past(cap_cli_q)) == $past(cap_cli_q))); // R5
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == U_HELD && ack && !hit) |=> (st_q == U_IDLE && cap_cli_q == '0)); // R6

endmodule

// File: rtl/bw_irq.sv
`timescale 1ns/100ps
module bw_irq #(
    parameter int NUM_UNITS = 4,
    parameter int UIDX_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] hit_i,
    input  logic                 mask_we_i,
    input  logic                 gack_we_i,
    input  logic [NUM_UNITS-1:0] wbits_i,
    output logic [NUM_UNITS-1:0] pend_o,
    output logic [NUM_UNITS-1:0] mask_o,
    output logic [NUM_UNITS-1:0] masked_o,
    output logic                 irq_o,
    output logic [UIDX_W-1:0]    irq_unit_o
);

    logic [NUM_UNITS-1:0] pend_q;
    logic [NUM_UNITS-1:0] mask_q;
    logic [NUM_UNITS-1:0] clr_bits;

    assign clr_bits = gack_we_i ? wbits_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_bits) | hit_i;
            if (mask_we_i) mask_q <= wbits_i;
        end
    end

    always_comb begin
        masked_o   = pend_q & mask_q;
        irq_o      = |masked_o;
        irq_unit_o = '0;
        for (int i = NUM_UNITS - 1; i >= 0; i--) begin
            if (masked_o[i]) irq_unit_o = UIDX_W'(i);
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_i) |=> ((pend_q & $past(hit_i)) == $past(hit_i)));                // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (gack_we_i && hit_i == '0) |=> ((pend_q & $past(wbits_i)) == '0));      // R7
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);                                             // R8
    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (masked_o[irq_unit_o] &&
                   ((masked_o & ((NUM_UNITS'(1) << irq_unit_o) - NUM_UNITS'(1))) == '0))); // R9

endmodule

// File: rtl/bw_watch.sv
`timescale 1ns/100ps
module bw_watch
    import bw_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int ADDR_W    = 32,
    parameter int NCLIENT   = 16,
    parameter int SIZE_W    = 4,
    parameter int DATA_W    = 32,
    localparam int CID_W    = (NCLIENT > 1) ? $clog2(NCLIENT) : 1,
    localparam int UIDX_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int REG_AW   = UIDX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [CID_W-1:0]  snp_cid,
    input  logic              snp_wr,
    input  logic [SIZE_W-1:0] snp_size,
    output logic              irq,
    output logic [UIDX_W-1:0] irq_unit
);

    logic                 is_glob;
    logic [UIDX_W-1:0]    uidx;
    logic [3:0]           ofs;
    logic [DATA_W-1:0]    unit_rd [NUM_UNITS];
    logic [NUM_UNITS-1:0] hit_vec;
    logic [NUM_UNITS-1:0] pend;
    logic [NUM_UNITS-1:0] mask;
    logic [NUM_UNITS-1:0] masked;

    assign is_glob = reg_addr[REG_AW-1];
    assign uidx    = reg_addr[REG_AW-2:4];
    assign ofs     = reg_addr[3:0];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        bw_unit #(
            .ADDR_W  (ADDR_W),
            .NCLIENT (NCLIENT),
            .CID_W   (CID_W),
            .SIZE_W  (SIZE_W),
            .DATA_W  (DATA_W)
        ) u_unit (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_we_i    (reg_we && !is_glob && (uidx == UIDX_W'(u))),
            .ofs_i       (ofs),
            .wdata_i     (reg_wdata),
            .rdata_o     (unit_rd[u]),
            .snp_valid_i (snp_valid),
            .snp_addr_i  (snp_addr),
            .snp_cid_i   (snp_cid),
            .snp_wr_i    (snp_wr),
            .snp_size_i  (snp_size),
            .hit_o       (hit_vec[u])
        );
    end

    bw_irq #(
        .NUM_UNITS (NUM_UNITS),
        .UIDX_W    (UIDX_W)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit_vec),
        .mask_we_i  (reg_we && is_glob && (ofs == GOFS_MASK)),
        .gack_we_i  (reg_we && is_glob && (ofs == GOFS_ACK)),
        .wbits_i    (reg_wdata[NUM_UNITS-1:0]),
        .pend_o     (pend),
        .mask_o     (mask),
        .masked_o   (masked),
        .irq_o      (irq),
        .irq_unit_o (irq_unit)
    );

    always_comb begin
        reg_rdata = '0;
        if (is_glob) begin
            case (ofs)
                GOFS_MASK:  reg_rdata = DATA_W'(mask);
                GOFS_MSTAT: reg_rdata = DATA_W'(masked);
                GOFS_PEND:  reg_rdata = DATA_W'(pend);
                GOFS_SEL:   reg_rdata = DATA_W'(irq_unit);
                default:    reg_rdata = '0;
            endcase
        end else begin
            reg_rdata = unit_rd[uidx];
        end
    end

endmodule

// File: tb/bw_watch_bench.sv
`timescale 1ns/100ps
module bw_watch_bench;
    import bw_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        snp_valid = 1'b0;
    logic [31:0] snp_addr = '0;
    logic [3:0]  snp_cid = '0;
    logic        snp_wr = 1'b0;
    logic [3:0]  snp_size = '0;
    logic        irq;
    logic [1:0]  irq_unit;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bw_watch u_bw_watch (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snp_valid(snp_valid),
        .snp_addr(snp_addr), .snp_cid(snp_cid), .snp_wr(snp_wr),
        .snp_size(snp_size), .irq(irq), .irq_unit(irq_unit)
    );

    // {valid, addr, cid, wr, size, expect_hit}; unit0 window 0x100..0x1FF, writes only, clients 4 and 5
    localparam logic [42:0] VEC [0:7] = '{
        {1'b1, 32'h0000_0100, 4'd4, 1'b1, 4'd1, 1'b1},
        {1'b1, 32'h0000_01FF, 4'd5, 1'b1, 4'd2, 1'b1},
        {1'b1, 32'h0000_00FF, 4'd4, 1'b1, 4'd1, 1'b0},
        {1'b1, 32'h0000_0200, 4'd4, 1'b1, 4'd1, 1'b0},
        {1'b1, 32'h0000_0150, 4'd4, 1'b0, 4'd1, 1'b0},
        {1'b1, 32'h0000_0150, 4'd3, 1'b1, 4'd1, 1'b0},
        {1'b0, 32'h0000_0150, 4'd5, 1'b1, 4'd1, 1'b0},
        {1'b1, 32'h0000_0180, 4'd4, 1'b1, 4'd4, 1'b1}
    };

    function automatic logic [6:0] ua(input int u, input logic [3:0] o);
        return 7'(u * 16) | {3'b000, o};
    endfunction

    function automatic logic [6:0] ga(input logic [3:0] o);
        return 7'h40 | {3'b000, o};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic snoop(input logic v, input logic [31:0] a, input logic [3:0] c,
                         input logic w, input logic [3:0] s);
        @(negedge clk);
        snp_valid = v; snp_addr = a; snp_cid = c; snp_wr = w; snp_size = s;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // register write and snooped access on the same edge
    task automatic wr_snoop(input logic [6:0] ra, input logic [31:0] d, input logic [31:0] a,
                            input logic [3:0] c, input logic w, input logic [3:0] s);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ra; reg_wdata = d;
        snp_valid = 1'b1; snp_addr = a; snp_cid = c; snp_wr = w; snp_size = s;
        @(negedge clk);
        reg_we = 1'b0; snp_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        v, w, e;
        logic [31:0] a;
        logic [3:0]  c, s;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(ua(0, OFS_FIRST), d);  check("R1 first", d, 0);
        rd(ua(0, OFS_CADDR), d);  check("R1 caddr", d, 0);
        rd(ua(3, OFS_STAT), d);   check("R1 stat", d, 0);
        rd(ga(GOFS_MASK), d);     check("R1 mask", d, 0);
        rd(ga(GOFS_PEND), d);     check("R1 pend", d, 0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 irq_unit", {30'd0, irq_unit}, 0);

        // unit0 configuration
        wr(ua(0, OFS_FIRST), 32'h100);
        wr(ua(0, OFS_LAST),  32'h1FF);
        wr(ua(0, OFS_OPM),   32'h2);
        wr(ua(0, OFS_CMASK), 32'h30);

        // R3 table walk
        for (int i = 0; i < 8; i++) begin
            {v, a, c, w, s, e} = VEC[i];
            wr(ua(0, OFS_ACK), 0);
            wr(ga(GOFS_ACK), 32'hF);
            snoop(v, a, c, w, s);
            rd(ga(GOFS_PEND), d);
            check($sformatf("R3 vec%0d pend", i), d, {31'd0, e});
            if (e) begin
                rd(ua(0, OFS_CADDR), d);
                check($sformatf("R3 vec%0d caddr", i), d, a);
            end
        end
        wr(ua(0, OFS_ACK), 0);
        wr(ga(GOFS_ACK), 32'hF);

        // R4 freeze, R5 client accumulation, R10 status
        snoop(1'b1, 32'h120, 4'd4, 1'b1, 4'd3);
        snoop(1'b1, 32'h130, 4'd5, 1'b1, 4'd7);
        rd(ua(0, OFS_CADDR), d);  check("R4 caddr frozen", d, 32'h120);
        rd(ua(0, OFS_CFIRST), d); check("R4 first client", d, 4);
        rd(ua(0, OFS_CSIZE), d);  check("R4 size", d, 3);
        rd(ua(0, OFS_COP), d);    check("R4 op", d, 1);
        rd(ua(0, OFS_CCLI), d);   check("R5 clients", d, 32'h30);
        rd(ua(0, OFS_STAT), d);   check("R10 held", d, 1);

        // R8 mask gating
        rd(ga(GOFS_MSTAT), d);    check("R8 mstat masked off", d, 0);
        check("R8 irq masked off", {31'd0, irq}, 0);
        wr(ga(GOFS_MASK), 32'h1);
        rd(ga(GOFS_MSTAT), d);    check("R8 mstat", d, 1);
        check("R8 irq", {31'd0, irq}, 1);
        rd(ga(GOFS_SEL), d);      check("R9 sel unit0", d, 0);

        // R7 hit and global ack in the same cycle
        wr_snoop(ga(GOFS_ACK), 32'h1, 32'h140, 4'd4, 1'b1, 4'd1);
        rd(ga(GOFS_PEND), d);     check("R7 set wins", d, 1);
        rd(ua(0, OFS_CADDR), d);  check("R4 still frozen", d, 32'h120);
        wr(ga(GOFS_ACK), 32'h1);
        rd(ga(GOFS_PEND), d);     check("R7 ack clears", d, 0);
        check("R7 irq low", {31'd0, irq}, 0);

        // R6 unit ack alone
        wr(ua(0, OFS_ACK), 32'h0);
        rd(ua(0, OFS_STAT), d);   check("R6 idle", d, 0);
        rd(ua(0, OFS_CADDR), d);  check("R6 caddr cleared", d, 0);
        rd(ua(0, OFS_CCLI), d);   check("R6 clients cleared", d, 0);

        // R6 unit ack with a hit in the same cycle
        snoop(1'b1, 32'h150, 4'd4, 1'b1, 4'd2);
        wr_snoop(ua(0, OFS_ACK), 32'h0, 32'h160, 4'd5, 1'b1, 4'd9);
        rd(ua(0, OFS_CADDR), d);  check("R6 reload addr", d, 32'h160);
        rd(ua(0, OFS_CFIRST), d); check("R6 reload client", d, 5);
        rd(ua(0, OFS_CSIZE), d);  check("R6 reload size", d, 9);
        rd(ua(0, OFS_CCLI), d);   check("R6 reload clients", d, 32'h20);
        rd(ua(0, OFS_STAT), d);   check("R10 held after reload", d, 1);

        // R2 readback of unit2, unit3 config
        wr(ua(2, OFS_FIRST), 32'h500);
        wr(ua(2, OFS_LAST),  32'h5FF);
        wr(ua(2, OFS_OPM),   32'h3);
        wr(ua(2, OFS_CMASK), 32'hFFFF);
        wr(ua(3, OFS_FIRST), 32'h500);
        wr(ua(3, OFS_LAST),  32'h5FF);
        wr(ua(3, OFS_OPM),   32'h3);
        wr(ua(3, OFS_CMASK), 32'hFFFF);
        rd(ua(2, OFS_FIRST), d);  check("R2 first", d, 32'h500);
        rd(ua(2, OFS_LAST), d);   check("R2 last", d, 32'h5FF);
        rd(ua(2, OFS_OPM), d);    check("R2 opm", d, 3);
        rd(ua(2, OFS_CMASK), d);  check("R2 cmask", d, 32'hFFFF);

        // R9 priority among pending units
        wr(ga(GOFS_ACK), 32'hF);
        wr(ga(GOFS_MASK), 32'hD);
        snoop(1'b1, 32'h510, 4'd1, 1'b0, 4'd1);
        rd(ga(GOFS_MSTAT), d);    check("R8 mstat units2,3", d, 32'hC);
        check("R9 irq_unit 2", {30'd0, irq_unit}, 2);
        wr(ga(GOFS_ACK), 32'h4);
        check("R9 irq_unit 3", {30'd0, irq_unit}, 3);
        snoop(1'b1, 32'h100, 4'd4, 1'b1, 4'd1);
        rd(ga(GOFS_SEL), d);      check("R9 sel unit0", d, 0);
        rd(ga(GOFS_PEND), d);     check("R7 pend", d, 32'h9);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule